// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block closes a digital gain loop around a record-path input amplifier. Each incoming 24-bit two's complement sample strobe is classified by its magnitude as above a programmable target level, below it, or (when the noise gate is enabled) below a gate threshold. A gain code of 64 steps, each 0.75 dB wide (code 0 is -12 dB, code 63 is +35.25 dB), is then walked down one step per attack interval while the signal is too loud, and walked up one step per decay interval once the signal has stayed quiet for the programmed hold time.

All timing is counted in ticks, where one tick is a fixed number of master clock cycles, so every interval scales with the master clock frequency. Two modes select different attack and decay ladders: a normal level-control mode and a faster limiter mode. The gain is always kept inside programmable minimum and maximum limits. When the loop is switched off, the gain code simply follows a manually written value.

Top module: `alc_gain_engine`

## Requirements
- R1: After reset the gain code is GAIN_RST (default 16, i.e. 0 dB) and the gate flag is 0.
- R2: While `alc_on` is 0 the gain code equals the `man_gain` value of the previous cycle and the gate flag is 0.
- R3: A sample whose magnitude (two's complement absolute value, negative samples included) exceeds the target amplitude counts as loud; the target amplitude is full scale times 10^((-22.5 + 1.5*min(tgt_lvl,14))/20).
- R4: While the latest sample is loud, the gain code falls by one per attack interval; the attack interval is (4 << min(atk_sel,10)) ticks in normal mode (`lim_mode`=0) and (1 << min(atk_sel,10)) ticks in limiter mode; a tick is TICK_CYC clock cycles.
- R5: After the latest sample becomes quiet, the gain code holds for a hold length of 0 ticks when `hold_sel` is 0 and HOLD_TICKS << (hold_sel-1) ticks otherwise.
- R6: After the hold length, the gain code rises by one per decay interval of (16 << min(dcy_sel,10)) ticks in normal mode and (4 << min(dcy_sel,10)) ticks in limiter mode.
- R7: While enabled, the gain code is never below `gain_min` nor above `gain_max`; if `gain_min` exceeds `gain_max`, the maximum wins.
- R8: With `gate_on` set, a sample whose magnitude is below full scale >> (GATE_SH + gate_lvl) freezes the gain code and raises the gate flag; the gate test takes priority over the target test.
- R9: While enabled with steady limits, the gain code never changes by more than one code between consecutive cycles.
- R10: The gain code saturates at 0 and 63 without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed audio sample |
| alc_on | input | 1 | Enable the gain loop |
| lim_mode | input | 1 | 1 selects limiter timing ladders |
| tgt_lvl | input | 4 | Target level code |
| hold_sel | input | 4 | Hold length select |
| atk_sel | input | 4 | Attack interval select |
| dcy_sel | input | 4 | Decay interval select |
| gain_max | input | GAIN_W | Upper gain limit code |
| gain_min | input | GAIN_W | Lower gain limit code |
| man_gain | input | GAIN_W | Manual gain code used while disabled |
| gate_on | input | 1 | Enable the noise gate |
| gate_lvl | input | 3 | Gate threshold select |
| gain_code | output | GAIN_W | Amplifier gain code |
| gate_flag | output | 1 | Noise gate active |

## Verification
The bench builds the engine with TICK_CYC set to 4 and HOLD_TICKS set to 2, keeping GATE_SH, the widths and the reset gain at their defaults. The short tick makes several attack and decay steps, multi-tick hold lengths and clamping against both limits reachable within a few hundred cycles, while the tick phase uncertainty stays smaller than the gap between gain steps so each expected code is exact. Longer selects only shift the same counters and are left to the interval formulas.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef enum logic [1:0] {
        LVL_UNDER = 2'd0,
        LVL_OVER  = 2'd1,
        LVL_GATED = 2'd2
    } lvl_cls_e;

    // Amplitude for target code t: full scale scaled down by 1.5 dB per step
    // below the top setting (0.841395 in Q16 per step).
    function automatic logic [63:0] target_amp(input int t, input int w);
        logic [63:0] v;
        int          n;
        v = 64'd1 << (w - 1);
        n = 15 - ((t > 14) ? 14 : t);
        for (int k = 0; k < n; k++) begin
            v = (v * 64'd55142) >> 16;
        end
        return v;
    endfunction

endpackage

// File: rtl/alc_tick_gen.sv
module alc_tick_gen #(
    parameter int TICK_CYC = 3072
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(TICK_CYC - 1)) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == CW'(TICK_CYC - 1));
endmodule

// File: rtl/alc_level_detect.sv
module alc_level_detect
    import alc_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int GATE_SH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [3:0]        tgt_lvl,
    input  logic              gate_on,
    input  logic [2:0]        gate_lvl,
    output lvl_cls_e          cls
);
    localparam logic [DATA_W-1:0] FULL = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] thr_tab [16];
    logic [DATA_W-1:0] mag, gate_thr;
    lvl_cls_e          cls_d, cls_q;

    for (genvar gi = 0; gi < 16; gi++) begin : g_thr
        assign thr_tab[gi] = DATA_W'(target_amp(gi, DATA_W));
    end

    always_comb begin
        mag      = smp_data[DATA_W-1] ? (~smp_data + 1'b1) : smp_data;
        gate_thr = FULL >> (GATE_SH + int'(gate_lvl));
        cls_d    = cls_q;
        if (smp_vld) begin
            if (gate_on && (mag < gate_thr)) cls_d = LVL_GATED;
            else if (mag > thr_tab[tgt_lvl])  cls_d = LVL_OVER;
            else                              cls_d = LVL_UNDER;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cls_q <= LVL_UNDER;
        else        cls_q <= cls_d;
    end

    assign cls = cls_q;
endmodule

// File: rtl/alc_gain_loop.sv
module alc_gain_loop
    import alc_pkg::*;
#(
    parameter int GAIN_W     = 6,
    parameter int CNT_W      = 32,
    parameter int HOLD_TICKS = 11,
    parameter int GAIN_RST   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  lvl_cls_e          cls,
    input  logic              alc_on,
    input  logic              lim_mode,
    input  logic [3:0]        hold_sel,
    input  logic [3:0]        atk_sel,
    input  logic [3:0]        dcy_sel,
    input  logic [GAIN_W-1:0] gain_max,
    input  logic [GAIN_W-1:0] gain_min,
    input  logic [GAIN_W-1:0] man_gain,
    output logic [GAIN_W-1:0] gain_code,
    output logic              gate_flag
);
    localparam logic [GAIN_W-1:0] GAIN_TOP = '1;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [CNT_W-1:0]  hold_cnt;
        logic [CNT_W-1:0]  step_cnt;
        lvl_cls_e          prev;
        logic              gate;
    } loop_st_t;

    loop_st_t d, q;

    logic [4:0]       atk_sh, dcy_sh;
    logic [CNT_W-1:0] atk_int, dcy_int, hold_len, step_base;

    always_comb begin
        atk_sh   = {1'b0, (atk_sel > 4'd10) ? 4'd10 : atk_sel} + (lim_mode ? 5'd0 : 5'd2);
        dcy_sh   = {1'b0, (dcy_sel > 4'd10) ? 4'd10 : dcy_sel} + (lim_mode ? 5'd2 : 5'd4);
        atk_int  = CNT_W'(1) << atk_sh;
        dcy_int  = CNT_W'(1) << dcy_sh;
        hold_len = (hold_sel == 4'd0) ? '0 : (CNT_W'(HOLD_TICKS) << (hold_sel - 4'd1));
        step_base = (cls != q.prev) ? '0 : q.step_cnt;

        d      = q;
        d.prev = cls;
        d.gate = alc_on && (cls == LVL_GATED);
        if (!alc_on) begin
            d.gain     = man_gain;
            d.hold_cnt = '0;
            d.step_cnt = '0;
        end else begin
            d.step_cnt = step_base;
            if (tick) begin
                unique case (cls)
                    LVL_OVER: begin
                        d.hold_cnt = '0;
                        if (step_base + 1'b1 >= atk_int) begin
                            d.step_cnt = '0;
                            if (q.gain != '0) d.gain = q.gain - 1'b1;
                        end else begin
                            d.step_cnt = step_base + 1'b1;
                        end
                    end
                    LVL_UNDER: begin
                        if (q.hold_cnt < hold_len) begin
                            d.hold_cnt = q.hold_cnt + 1'b1;
                            d.step_cnt = '0;
                        end else if (step_base + 1'b1 >= dcy_int) begin
                            d.step_cnt = '0;
                            if (q.gain != GAIN_TOP) d.gain = q.gain + 1'b1;
                        end else begin
                            d.step_cnt = step_base + 1'b1;
                        end
                    end
                    default: d.step_cnt = '0;
                endcase
            end
            if (d.gain < gain_min) d.gain = gain_min;
            if (d.gain > gain_max) d.gain = gain_max;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.gain     <= GAIN_W'(GAIN_RST);
            q.hold_cnt <= '0;
            q.step_cnt <= '0;
            q.prev     <= LVL_UNDER;
            q.gate     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign gain_code = q.gain;
    assign gate_flag = q.gate;
endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
    import alc_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int GAIN_W     = 6,
    parameter int CNT_W      = 32,
    parameter int TICK_CYC   = 3072,
    parameter int HOLD_TICKS = 11,
    parameter int GATE_SH    = 4,
    parameter int GAIN_RST   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              alc_on,
    input  logic              lim_mode,
    input  logic [3:0]        tgt_lvl,
    input  logic [3:0]        hold_sel,
    input  logic [3:0]        atk_sel,
    input  logic [3:0]        dcy_sel,
    input  logic [GAIN_W-1:0] gain_max,
    input  logic [GAIN_W-1:0] gain_min,
    input  logic [GAIN_W-1:0] man_gain,
    input  logic              gate_on,
    input  logic [2:0]        gate_lvl,
    output logic [GAIN_W-1:0] gain_code,
    output logic              gate_flag
);
    logic     tick;
    lvl_cls_e cls;

    alc_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    alc_level_detect #(.DATA_W(DATA_W), .GATE_SH(GATE_SH)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp_data(smp_data),
        .tgt_lvl (tgt_lvl),
        .gate_on (gate_on),
        .gate_lvl(gate_lvl),
        .cls     (cls)
    );

    alc_gain_loop #(
        .GAIN_W(GAIN_W), .CNT_W(CNT_W),
        .HOLD_TICKS(HOLD_TICKS), .GAIN_RST(GAIN_RST)
    ) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cls      (cls),
        .alc_on   (alc_on),
        .lim_mode (lim_mode),
        .hold_sel (hold_sel),
        .atk_sel  (atk_sel),
        .dcy_sel  (dcy_sel),
        .gain_max (gain_max),
        .gain_min (gain_min),
        .man_gain (man_gain),
        .gain_code(gain_code),
        .gate_flag(gate_flag)
    );
endmodule

// File: rtl/alc_gain_engine_chk.sv
module alc_gain_engine_chk #(
    parameter int GAIN_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alc_on,
    input logic              gate_on,
    input logic [GAIN_W-1:0] gain_max,
    input logic [GAIN_W-1:0] gain_min,
    input logic [GAIN_W-1:0] man_gain,
    input logic [GAIN_W-1:0] gain_code,
    input logic              gate_flag
);
    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_on |=> (gain_code == $past(man_gain))); // R2

    AST_GAIN_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alc_on) && ($past(gain_min) <= $past(gain_max)))
        |-> ((gain_code >= $past(gain_min)) && (gain_code <= $past(gain_max)))); // R7

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_flag && $past(alc_on, 2)
         && ($past(gain_max) == $past(gain_max, 2))
         && ($past(gain_min) == $past(gain_min, 2)))
        |-> (gain_code == $past(gain_code))); // R8

    AST_GATE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_flag |-> ($past(alc_on) && $past(gate_on))); // R8

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alc_on) && $past(alc_on, 2)
         && ($past(gain_max) == $past(gain_max, 2))
         && ($past(gain_min) == $past(gain_min, 2)))
        |-> ((gain_code == $past(gain_code))
             || (gain_code == $past(gain_code) + 1'b1)
             || (gain_code == $past(gain_code) - 1'b1))); // R9
endmodule

bind alc_gain_engine alc_gain_engine_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alc_on   (alc_on),
    .gate_on  (gate_on),
    .gain_max (gain_max),
    .gain_min (gain_min),
    .man_gain (man_gain),
    .gain_code(gain_code),
    .gate_flag(gate_flag)
);

// File: tb/alc_gain_engine_test.sv
`timescale 1ns/1ps
module alc_gain_engine_test;
    localparam int DATA_W = 24;
    localparam int GAIN_W = 6;
    localparam int TCYC   = 4;
    localparam int HTICK  = 2;

    typedef struct packed {
        logic        lim;
        logic [3:0]  atk;
        logic [3:0]  dcy;
        logic [3:0]  hold;
        logic [3:0]  tgt;
        logic        gate;
        logic [23:0] smp;
        logic [5:0]  gmin;
        logic [5:0]  gmax;
        logic [5:0]  start;
        logic [1:0]  kind;   // 0 quiet, 1 loud, 2 gated
        logic [7:0]  steps;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 4'd0, 4'd0, 4'd10, 1'b0, 24'd6000000,   6'd0,  6'd63, 6'd40, 2'd1, 8'd3, 8'd4},  // R4 normal attack
        '{1'b0, 4'd1, 4'd0, 4'd0, 4'd10, 1'b0, -24'sd6000000, 6'd0,  6'd63, 6'd40, 2'd1, 8'd2, 8'd3},  // R3 negative sample
        '{1'b1, 4'd2, 4'd0, 4'd0, 4'd10, 1'b0, 24'd6000000,   6'd0,  6'd63, 6'd30, 2'd1, 8'd5, 8'd4},  // R4 limiter attack
        '{1'b0, 4'd0, 4'd0, 4'd0, 4'd10, 1'b0, 24'd1000000,   6'd0,  6'd63, 6'd20, 2'd0, 8'd2, 8'd6},  // R6 normal decay
        '{1'b1, 4'd0, 4'd0, 4'd2, 4'd10, 1'b0, 24'd1000000,   6'd0,  6'd63, 6'd20, 2'd0, 8'd5, 8'd5},  // R5 hold then decay
        '{1'b1, 4'd0, 4'd1, 4'd3, 4'd10, 1'b0, 24'd1000000,   6'd0,  6'd63, 6'd10, 2'd0, 8'd2, 8'd5},  // R5 longer hold
        '{1'b0, 4'd0, 4'd0, 4'd0, 4'd10, 1'b0, 24'd6000000,   6'd35, 6'd63, 6'd40, 2'd1, 8'd8, 8'd7},  // R7 floor
        '{1'b1, 4'd0, 4'd0, 4'd0, 4'd10, 1'b0, 24'd1000000,   6'd0,  6'd24, 6'd20, 2'd0, 8'd8, 8'd7},  // R7 ceiling
        '{1'b0, 4'd0, 4'd0, 4'd0, 4'd0,  1'b0, 24'd1000000,   6'd0,  6'd63, 6'd40, 2'd1, 8'd2, 8'd3},  // R3 lowest target
        '{1'b1, 4'd0, 4'd0, 4'd0, 4'd15, 1'b0, 24'd6000000,   6'd0,  6'd63, 6'd40, 2'd0, 8'd3, 8'd3},  // R3 highest target
        '{1'b1, 4'd0, 4'd0, 4'd0, 4'd10, 1'b1, 24'd1000,      6'd0,  6'd63, 6'd30, 2'd2, 8'd10, 8'd8}, // R8 gated
        '{1'b1, 4'd0, 4'd0, 4'd0, 4'd10, 1'b1, 24'd1000000,   6'd0,  6'd63, 6'd30, 2'd0, 8'd2, 8'd8},  // R8 above gate
        '{1'b0, 4'd0, 4'd0, 4'd0, 4'd10, 1'b0, 24'd6000000,   6'd0,  6'd63, 6'd1,  2'd1, 8'd3, 8'd10}, // R10 floor 0
        '{1'b1, 4'd0, 4'd0, 4'd0, 4'd10, 1'b0, 24'd1000000,   6'd0,  6'd63, 6'd62, 2'd0, 8'd3, 8'd10}  // R10 top 63
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              alc_on = 1'b0;
    logic              lim_mode = 1'b0;
    logic [3:0]        tgt_lvl = 4'd10;
    logic [3:0]        hold_sel = '0;
    logic [3:0]        atk_sel = '0;
    logic [3:0]        dcy_sel = '0;
    logic [GAIN_W-1:0] gain_max = 6'd63;
    logic [GAIN_W-1:0] gain_min = 6'd0;
    logic [GAIN_W-1:0] man_gain = 6'd16;
    logic              gate_on = 1'b0;
    logic [2:0]        gate_lvl = '0;
    logic [GAIN_W-1:0] gain_code;
    logic              gate_flag;

    int n_run = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    alc_gain_engine #(.TICK_CYC(TCYC), .HOLD_TICKS(HTICK)) uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .alc_on(alc_on), .lim_mode(lim_mode), .tgt_lvl(tgt_lvl),
        .hold_sel(hold_sel), .atk_sel(atk_sel), .dcy_sel(dcy_sel),
        .gain_max(gain_max), .gain_min(gain_min), .man_gain(man_gain),
        .gate_on(gate_on), .gate_lvl(gate_lvl),
        .gain_code(gain_code), .gate_flag(gate_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [23:0] s);
        @(negedge clk);
        smp_data = s;
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 gain after reset", int'(gain_code), 16);
        check("R1 gate after reset", int'(gate_flag), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            int a_int, d_int, h_len, ticks, e;
            vec_t v;
            v = VECS[i];
            @(negedge clk);
            alc_on   = 1'b0;
            man_gain = v.start;
            lim_mode = v.lim;
            atk_sel  = v.atk;
            dcy_sel  = v.dcy;
            hold_sel = v.hold;
            tgt_lvl  = v.tgt;
            gate_on  = v.gate;
            gate_lvl = 3'd0;
            gain_min = v.gmin;
            gain_max = v.gmax;
            strobe(v.smp);
            alc_on = 1'b1;
            a_int = v.lim ? (1 << v.atk) : (4 << v.atk);
            d_int = v.lim ? (4 << v.dcy) : (16 << v.dcy);
            h_len = (v.hold == 0) ? 0 : (HTICK << (v.hold - 1));
            case (v.kind)
                2'd1:    begin ticks = int'(v.steps) * a_int;         e = int'(v.start) - int'(v.steps); end
                2'd0:    begin ticks = h_len + int'(v.steps) * d_int; e = int'(v.start) + int'(v.steps); end
                default: begin ticks = int'(v.steps);                e = int'(v.start); end
            endcase
            if (e < 0) e = 0;
            if (e > 63) e = 63;
            if (e < int'(v.gmin)) e = int'(v.gmin);
            if (e > int'(v.gmax)) e = int'(v.gmax);
            repeat (ticks * TCYC + 3) @(negedge clk);
            check($sformatf("R%0d vector %0d gain", v.req, i), int'(gain_code), e);
            if (v.kind == 2'd2)
                check("R8 gate flag raised", int'(gate_flag), 1);
        end

        // R8: gate flag drops once disabled
        alc_on = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 gate flag off when disabled", int'(gate_flag), 0);
        gate_on = 1'b0;

        // R2: manual gain followed while disabled
        man_gain = 6'd45;
        @(negedge clk);
        check("R2 manual gain 45", int'(gain_code), 45);
        man_gain = 6'd7;
        @(negedge clk);
        check("R2 manual gain 7", int'(gain_code), 7);

        // R7: min above max, maximum wins
        man_gain = 6'd50;
        gain_min = 6'd40;
        gain_max = 6'd30;
        @(negedge clk);
        alc_on = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 max wins over min", int'(gain_code), 30);

        // R7: limit lowered while running pulls gain inside
        gain_min = 6'd0;
        gain_max = 6'd63;
        @(negedge clk);
        gain_max = 6'd12;
        @(negedge clk);
        check("R7 lowered ceiling", int'(gain_code), 12);

        // R9: fast limiter attack never jumps more than one code per cycle
        alc_on   = 1'b0;
        man_gain = 6'd40;
        gain_max = 6'd63;
        lim_mode = 1'b1;
        atk_sel  = 4'd0;
        strobe(24'd6000000);
        alc_on = 1'b1;
        @(negedge clk);
        begin
            int prev, worst;
            prev  = int'(gain_code);
            worst = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if ((int'(gain_code) - prev > worst)) worst = int'(gain_code) - prev;
                if ((prev - int'(gain_code) > worst)) worst = prev - int'(gain_code);
                prev = int'(gain_code);
            end
            check("R9 largest per-cycle change", worst, 1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule